// File: doc/BRIEF.md
# Backplane Bay Status and Hot-Swap Event Registers

This block sits on a simple byte-addressed register bus inside a seven-bay chassis controller. On each read it builds a power-good word from the live bay presence inputs. Bay 0 is always powered. Every other bay contributes a pair of adjacent bits, and those pairs are spread over the word in a fixed, non-contiguous order. The block also latches hot-swap events on bays 1 to 6 and SRAM error events into sticky status bits, and raises a hot-swap interrupt when any of them arrives.

A separate management interrupt is raised by an external management-event pulse. Software reads a management word, which is the power-good word masked down to the power bits of bays 1 to 6. Any access to that word drops the management interrupt. The hot-swap interrupt drops when software reads the event word or clears bits in it by writing ones. One plain 32-bit control register, one constant all-ones word and one reserved zero word complete the map.

Reads have one cycle of latency. The data for a read strobe appears on `regRdata` in the following cycle, and `regRdata` is zero in every other cycle.

Top module: `slot_status_regs`

## Requirements
- R1: A read of offset 0x50 always returns bits 1 and 2 set (bay 0 is always powered), whatever the presence inputs are.
- R2: In the offset 0x50 word, bay n (bayPresent[n-1]) owns a pair of adjacent bits starting at bit 9 (bay 1), 13 (bay 2), 25 (bay 3), 17 (bay 4), 29 (bay 5) or 21 (bay 6). A pair reads 11 when that bay is present and 00 otherwise. All other bits read 0, and the word reflects the presence inputs in the cycle of the read strobe.
- R3: Offset 0x58 is a 32-bit control register: a write stores regWdata and a later read returns it.
- R4: A read of offset 0x40 returns the offset 0x50 word ANDed with 0x66666600. A mgmtEvt pulse sets mgmtIrq at the next edge. Any read or write of 0x40 clears mgmtIrq at the next edge, unless mgmtEvt is high in the same cycle, in which case mgmtIrq stays set.
- R5: A pulse on hotSwapEvt[i] sets event bit i+1 at offset 0x70, and a pulse on sramErrEvt sets bit 7. Either one sets hotSwapIrq at the next edge. Bits 0 and 8..31 read 0.
- R6: A read of offset 0x70 returns the event bits as they were before that edge and clears hotSwapIrq, but leaves the bits unchanged.
- R7: A write to offset 0x70 clears each event bit whose regWdata bit is 1 and clears hotSwapIrq. If an event arrives in the same cycle, its bit stays set and hotSwapIrq stays high.
- R8: Offset 0x48 always reads 0xFFFFFFFF. Offset 0x78 always reads 0, and writes to it change no state.
- R9: Offsets outside the map read 0, and writes to them change no register.
- R10: After reset the control register, the event bits, both interrupts and regRdata are all zero.
- R11: regRdata carries the read value in the cycle after regRd and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset of the access |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after regRd |
| bayPresent | input | 6 | Presence of bays 1..6 (bit 0 = bay 1) |
| hotSwapEvt | input | 6 | Hot-swap event pulses for bays 1..6 |
| sramErrEvt | input | 1 | SRAM error event pulse |
| mgmtEvt | input | 1 | Management event pulse |
| hotSwapIrq | output | 1 | Hot-swap/error interrupt |
| mgmtIrq | output | 1 | Management interrupt |

## Verification
The bound checker checks on every cycle:
- the fixed bay-0 bits and the management mask on every read of those offsets;
- the all-ones constant word;
- that regRdata is zero after a cycle with no read;
- that each interrupt rises after its event and falls after a read or a clear that comes with no event.

Only the bench's scenarios can show the parts that need the history of earlier writes and events:
- the bay-by-bay scattered bit placement under different presence patterns;
- write-one-to-clear on selected bits;
- the event-over-clear priority on the same bit;
- that the reserved and unmapped offsets leave the control register untouched.

// File: rtl/slotreg_pkg.sv
`timescale 1ns/1ps
package slotreg_pkg;

  localparam logic [7:0] OFF_MGMT  = 8'h40;
  localparam logic [7:0] OFF_ONES  = 8'h48;
  localparam logic [7:0] OFF_PORT  = 8'h50;
  localparam logic [7:0] OFF_CTL   = 8'h58;
  localparam logic [7:0] OFF_HS    = 8'h70;
  localparam logic [7:0] OFF_RSVD  = 8'h78;

  localparam logic [31:0] MGMT_MASK = 32'h6666_6600;

  // Strobes decoded by the control path for the datapath
  typedef struct packed {
    logic rdPort;
    logic rdMgmt;
    logic rdOnes;
    logic rdCtl;
    logic rdHs;
    logic wrCtl;
    logic wrHs;
    logic hitMgmt;
    logic anyRd;
  } strobe_t;

  // Lowest bit of the power-good pair owned by a bay
  function automatic int pwrBase(input int bay);
    case (bay)
      0:       return 1;
      1:       return 9;
      2:       return 13;
      3:       return 25;
      4:       return 17;
      5:       return 29;
      default: return 21;
    endcase
  endfunction

endpackage

// File: rtl/slotreg_ctrl.sv
`timescale 1ns/1ps
module slotreg_ctrl
  import slotreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output strobe_t           strobes
);

  logic hitMgmt, hitOnes, hitPort, hitCtl, hitHs;

  assign hitMgmt = (regAddr == ADDR_W'(OFF_MGMT));
  assign hitOnes = (regAddr == ADDR_W'(OFF_ONES));
  assign hitPort = (regAddr == ADDR_W'(OFF_PORT));
  assign hitCtl  = (regAddr == ADDR_W'(OFF_CTL));
  assign hitHs   = (regAddr == ADDR_W'(OFF_HS));

  always_comb begin
    strobes         = '0;
    strobes.anyRd   = regRd;
    strobes.rdPort  = regRd & hitPort;
    strobes.rdMgmt  = regRd & hitMgmt;
    strobes.rdOnes  = regRd & hitOnes;
    strobes.rdCtl   = regRd & hitCtl;
    strobes.rdHs    = regRd & hitHs;
    strobes.wrCtl   = regWr & hitCtl;
    strobes.wrHs    = regWr & hitHs;
    strobes.hitMgmt = (regRd | regWr) & hitMgmt;
  end

endmodule

// File: rtl/slotreg_datapath.sv
`timescale 1ns/1ps
module slotreg_datapath
  import slotreg_pkg::*;
#(
  parameter int NUM_BAYS = 7,
  parameter int DATA_W   = 32,
  localparam int PRES_W  = NUM_BAYS - 1,
  localparam int HS_W    = NUM_BAYS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PRES_W-1:0] bayPresent,
  input  logic [PRES_W-1:0] hotSwapEvt,
  input  logic              sramErrEvt,
  input  logic              mgmtEvt,
  output logic [DATA_W-1:0] regRdata,
  output logic              hotSwapIrq,
  output logic              mgmtIrq
);

  logic [DATA_W-1:0] bayMask [NUM_BAYS];
  logic [DATA_W-1:0] portStat;
  logic [DATA_W-1:0] ctlReg;
  logic [HS_W-1:0]   hsStat, hsNext, evtVec;
  logic [DATA_W-1:0] rdNext;

  // Per-bay power-good pair, placed at its scattered position
  for (genvar b = 0; b < NUM_BAYS; b++) begin : gBay
    localparam int BASE = pwrBase(b);
    logic bayOn;
    if (b == 0) begin : gFixed
      assign bayOn = 1'b1;
    end else begin : gLive
      assign bayOn = bayPresent[b-1];
    end
    assign bayMask[b] = bayOn ? (DATA_W'(2'b11) << BASE) : '0;
  end

  always_comb begin
    portStat = '0;
    for (int b = 0; b < NUM_BAYS; b++) portStat |= bayMask[b];
  end

  assign evtVec = {sramErrEvt, hotSwapEvt, 1'b0};

  always_comb begin
    hsNext = hsStat;
    if (strobes.wrHs) hsNext &= ~regWdata[HS_W-1:0];
    hsNext   |= evtVec;
    hsNext[0] = 1'b0;
  end

  always_comb begin
    rdNext = '0;
    if (strobes.rdPort)      rdNext = portStat;
    else if (strobes.rdMgmt) rdNext = portStat & DATA_W'(MGMT_MASK);
    else if (strobes.rdOnes) rdNext = '1;
    else if (strobes.rdCtl)  rdNext = ctlReg;
    else if (strobes.rdHs)   rdNext = DATA_W'(hsStat);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg     <= '0;
      hsStat     <= '0;
      hotSwapIrq <= 1'b0;
      mgmtIrq    <= 1'b0;
      regRdata   <= '0;
    end else begin
      if (strobes.wrCtl) ctlReg <= regWdata;
      hsStat <= hsNext;
      if (|evtVec)                           hotSwapIrq <= 1'b1;
      else if (strobes.rdHs || strobes.wrHs) hotSwapIrq <= 1'b0;
      if (mgmtEvt)              mgmtIrq <= 1'b1;
      else if (strobes.hitMgmt) mgmtIrq <= 1'b0;
      regRdata <= strobes.anyRd ? rdNext : '0;
    end
  end

endmodule

// File: rtl/slot_status_regs.sv
`timescale 1ns/1ps
module slot_status_regs
  import slotreg_pkg::*;
#(
  parameter int NUM_BAYS = 7,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regRd,
  input  logic                regWr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_BAYS-2:0] bayPresent,
  input  logic [NUM_BAYS-2:0] hotSwapEvt,
  input  logic                sramErrEvt,
  input  logic                mgmtEvt,
  output logic                hotSwapIrq,
  output logic                mgmtIrq
);

  strobe_t strobes;

  slotreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .strobes (strobes)
  );

  slotreg_datapath #(.NUM_BAYS(NUM_BAYS), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWdata   (regWdata),
    .bayPresent (bayPresent),
    .hotSwapEvt (hotSwapEvt),
    .sramErrEvt (sramErrEvt),
    .mgmtEvt    (mgmtEvt),
    .regRdata   (regRdata),
    .hotSwapIrq (hotSwapIrq),
    .mgmtIrq    (mgmtIrq)
  );

endmodule

// File: rtl/slotreg_checker.sv
`timescale 1ns/1ps
module slotreg_checker
  import slotreg_pkg::*;
#(
  parameter int NUM_BAYS = 7,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regRd,
  input logic                regWr,
  input logic [DATA_W-1:0]   regRdata,
  input logic [NUM_BAYS-2:0] hotSwapEvt,
  input logic                sramErrEvt,
  input logic                mgmtEvt,
  input logic                hotSwapIrq,
  input logic                mgmtIrq
);

  logic anyEvt;
  assign anyEvt = (|hotSwapEvt) | sramErrEvt;

  a_r1_bay0_powered: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFF_PORT)) |=> (regRdata[2:1] == 2'b11));

  a_r4_mgmt_masked: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFF_MGMT)) |=> ((regRdata & ~DATA_W'(MGMT_MASK)) == '0));

  a_r4_mgmt_set: assert property (@(posedge clk) disable iff (!rstN)
    mgmtEvt |=> mgmtIrq);

  a_r4_mgmt_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((regRd || regWr) && regAddr == ADDR_W'(OFF_MGMT) && !mgmtEvt) |=> !mgmtIrq);

  a_r5_event_irq: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt |=> hotSwapIrq);

  a_r6_read_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFF_HS) && !anyEvt) |=> !hotSwapIrq);

  a_r7_write_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(OFF_HS) && !anyEvt) |=> !hotSwapIrq);

  a_r8_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(OFF_ONES)) |=> (regRdata == '1));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> (regRdata == '0));

endmodule

bind slot_status_regs slotreg_checker #(
  .NUM_BAYS(NUM_BAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regRd      (regRd),
  .regWr      (regWr),
  .regRdata   (regRdata),
  .hotSwapEvt (hotSwapEvt),
  .sramErrEvt (sramErrEvt),
  .mgmtEvt    (mgmtEvt),
  .hotSwapIrq (hotSwapIrq),
  .mgmtIrq    (mgmtIrq)
);

// File: tb/tb_slot_status_regs.sv
`timescale 1ns/1ps
module tb_slot_status_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  bayPresent = '0;
  logic [5:0]  hotSwapEvt = '0;
  logic        sramErrEvt = 1'b0;
  logic        mgmtEvt = 1'b0;
  logic        hotSwapIrq, mgmtIrq;

  int    nTests = 0;
  int    nFail  = 0;
  string curReq = "R10";
  bit    finished = 0;

  always #5 clk = ~clk;

  slot_status_regs dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .bayPresent(bayPresent),
    .hotSwapEvt(hotSwapEvt), .sramErrEvt(sramErrEvt), .mgmtEvt(mgmtEvt),
    .hotSwapIrq(hotSwapIrq), .mgmtIrq(mgmtIrq)
  );

  // Reference model
  logic [31:0] mCtl, mHs, mRd;
  bit          mHsIrq, mMgIrq;

  function automatic logic [31:0] portWord(input logic [5:0] pres);
    logic [31:0] w;
    w = 32'h0000_0006;
    if (pres[0]) w[10:9]  = 2'b11;
    if (pres[1]) w[14:13] = 2'b11;
    if (pres[2]) w[26:25] = 2'b11;
    if (pres[3]) w[18:17] = 2'b11;
    if (pres[4]) w[30:29] = 2'b11;
    if (pres[5]) w[22:21] = 2'b11;
    return w;
  endfunction

  function automatic logic [31:0] readWord(input logic [7:0] a);
    case (a)
      8'h50:   return portWord(bayPresent);
      8'h40:   return portWord(bayPresent) & 32'h6666_6600;
      8'h48:   return 32'hFFFF_FFFF;
      8'h58:   return mCtl;
      8'h70:   return mHs;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtl = 0; mHs = 0; mRd = 0; mHsIrq = 0; mMgIrq = 0;
    end else begin
      logic [31:0] evts;
      evts = {24'h0, sramErrEvt, hotSwapEvt, 1'b0};
      mRd = regRd ? readWord(regAddr) : 32'h0;
      if (regWr && regAddr == 8'h58) mCtl = regWdata;
      if (regWr && regAddr == 8'h70) mHs = mHs & ~regWdata;
      mHs = (mHs | evts) & 32'h0000_00FE;
      if (evts != 0) mHsIrq = 1;
      else if ((regRd || regWr) && regAddr == 8'h70) mHsIrq = 0;
      if (mgmtEvt) mMgIrq = 1;
      else if ((regRd || regWr) && regAddr == 8'h40) mMgIrq = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check({curReq, " rdata"}, regRdata, mRd);
      check({curReq, " hsIrq"}, {31'h0, hotSwapIrq}, {31'h0, mHsIrq});
      check({curReq, " mgIrq"}, {31'h0, mgmtIrq}, {31'h0, mMgIrq});
    end
  end

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); regAddr = a; regWdata = v; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    curReq = "R10";
    check("R10 hsIrq after reset", {31'h0, hotSwapIrq}, 32'h0);
    check("R10 mgmtIrq after reset", {31'h0, mgmtIrq}, 32'h0);
    rd(8'h58, d); check("R10 ctl after reset", d, 32'h0);
    rd(8'h70, d); check("R10 events after reset", d, 32'h0);

    curReq = "R11";
    idle(2);
    check("R11 idle rdata", regRdata, 32'h0);

    curReq = "R1";
    rd(8'h50, d); check("R1 bay0 only", d, 32'h0000_0006);

    curReq = "R2";
    bayPresent = 6'b111111;
    rd(8'h50, d); check("R2 all bays", d, 32'h6666_6606);
    bayPresent = 6'b000100;
    rd(8'h50, d); check("R2 bay3 only", d, 32'h0600_0006);
    bayPresent = 6'b101010;
    rd(8'h50, d); check("R2 bays 2,4,6", d, 32'h0066_6006);
    bayPresent = 6'b010001;
    rd(8'h50, d); check("R2 bays 1,5", d, 32'h6000_0606);

    curReq = "R3";
    wr(8'h58, 32'hA5C3_0F01);
    rd(8'h58, d); check("R3 ctl readback", d, 32'hA5C3_0F01);

    curReq = "R4";
    bayPresent = 6'b111111;
    @(negedge clk); mgmtEvt = 1'b1;
    @(negedge clk); mgmtEvt = 1'b0;
    check("R4 mgmtIrq set", {31'h0, mgmtIrq}, 32'h1);
    rd(8'h40, d); check("R4 masked word", d, 32'h6666_6600);
    check("R4 mgmtIrq cleared by read", {31'h0, mgmtIrq}, 32'h0);
    @(negedge clk); mgmtEvt = 1'b1;
    @(negedge clk); mgmtEvt = 1'b0;
    wr(8'h40, 32'h0);
    check("R4 mgmtIrq cleared by write", {31'h0, mgmtIrq}, 32'h0);
    @(negedge clk); mgmtEvt = 1'b1; regAddr = 8'h40; regRd = 1'b1;
    @(negedge clk); mgmtEvt = 1'b0; regRd = 1'b0;
    check("R4 event wins over access", {31'h0, mgmtIrq}, 32'h1);
    rd(8'h40, d);

    curReq = "R5";
    @(negedge clk); hotSwapEvt = 6'b000101;
    @(negedge clk); hotSwapEvt = 6'b0;
    check("R5 irq on bay event", {31'h0, hotSwapIrq}, 32'h1);
    @(negedge clk); sramErrEvt = 1'b1;
    @(negedge clk); sramErrEvt = 1'b0;

    curReq = "R6";
    rd(8'h70, d); check("R6 event word", d, 32'h0000_008A);
    check("R6 irq cleared", {31'h0, hotSwapIrq}, 32'h0);
    rd(8'h70, d); check("R6 bits kept", d, 32'h0000_008A);

    curReq = "R7";
    @(negedge clk); hotSwapEvt = 6'b000001;
    @(negedge clk); hotSwapEvt = 6'b0;
    wr(8'h70, 32'h0000_0088);
    check("R7 irq cleared by write", {31'h0, hotSwapIrq}, 32'h0);
    rd(8'h70, d); check("R7 w1c", d, 32'h0000_0002);
    @(negedge clk); regAddr = 8'h70; regWdata = 32'hFF; regWr = 1'b1; hotSwapEvt = 6'b000001;
    @(negedge clk); regWr = 1'b0; hotSwapEvt = 6'b0;
    check("R7 event beats clear irq", {31'h0, hotSwapIrq}, 32'h1);
    rd(8'h70, d); check("R7 event beats clear bit", d, 32'h0000_0002);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, d); check("R7 all cleared", d, 32'h0);

    curReq = "R8";
    rd(8'h48, d); check("R8 all ones", d, 32'hFFFF_FFFF);
    wr(8'h78, 32'h1234_5678);
    rd(8'h78, d); check("R8 reserved reads zero", d, 32'h0);
    rd(8'h58, d); check("R8 ctl untouched", d, 32'hA5C3_0F01);

    curReq = "R9";
    wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h5C, 32'hDEAD_BEEF);
    rd(8'h30, d); check("R9 unmapped zero", d, 32'h0);
    rd(8'h58, d); check("R9 ctl untouched", d, 32'hA5C3_0F01);
    rd(8'h70, d); check("R9 events untouched", d, 32'h0);

    idle(3);
    finish();
  end

endmodule